// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns an integer held in a 64-bit source word into an IEEE 754 binary64 value. The integer may be signed or unsigned, and either 32 bits wide (taken from the low half of the source) or 64 bits wide. A precision select picks the result format. In double mode the value is rounded to a 53-bit significand. In single mode it is rounded to a 24-bit significand and binary32 exponent range, and then written out exactly in binary64 register layout.

Rounding follows a 2-bit dynamic mode. Alongside the value the block reports an inexact flag, a fraction-rounded flag (the rounded magnitude grew) and a 5-bit result class code. A 32-bit source converted in double mode always fits exactly. That case bypasses rounding: every flag stays clear and the class code reads zero.

The datapath takes the magnitude of the source, counts its leading zeros, shifts it to a normalised position and feeds one rounding stage per precision. All outputs are registered, one cycle after the inputs.

Top module: `itof_convert`

## Requirements
- R1: The type select `int_kind` encodes 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit and 3 = unsigned 64-bit. For 32-bit types only bits 31:0 of `int_src` matter, and bits 63:32 have no effect on any output.
- R2: When `single_sel`=0 and the type is 32-bit, the result is the exact binary64 value, and `inexact`, `frac_rounded` and `fp_class` are all zero.
- R3: On the rounding path the result is the source rounded to a 53-bit significand. `rnd_mode` selects the rounding: 00 = nearest-even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity.
- R4: With `single_sel`=1 the value is rounded to a 24-bit significand, then widened exactly. The exponent field is the unbiased exponent plus 1023, and fraction bits 28:0 are zero.
- R5: On the rounding path `inexact` is 1 exactly when the rounded value differs from the source value.
- R6: On the rounding path `frac_rounded` is 1 exactly when the rounded magnitude exceeds the exact magnitude. It is never 1 without `inexact`.
- R7: On the rounding path `fp_class` is 00010 for +0, 00100 for a positive normal and 01000 for a negative normal.
- R8: A zero source gives the all-zero result (+0.0) for every type, precision and mode.
- R9: A negative signed source is converted as its magnitude with bit 63 set. The most negative 32-bit and 64-bit values are included. Unsigned sources never set bit 63.
- R10: When the discarded bits are exactly half a unit in the last place, nearest-even rounds to the even significand.
- R11: Outputs register the conversion of the inputs present at the previous rising clock edge. An active-low `rst_n` clears all outputs to zero asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | 64 | Integer source word |
| int_kind | input | 2 | Integer type select |
| single_sel | input | 1 | 1 = round to binary32 precision |
| rnd_mode | input | 2 | Rounding mode |
| fp_result | output | 64 | Converted value in binary64 layout |
| fp_class | output | 5 | Result class code |
| inexact | output | 1 | Rounding changed the value |
| frac_rounded | output | 1 | Rounded magnitude exceeds the exact one |

## Verification
The assertions check the following on every cycle:
- The bypass case leaves its flags and class clear.
- Single-precision results carry 29 zero fraction bits.
- An internal round-up event always appears as `frac_rounded` one cycle later, and never when rounding toward zero.
- Zero sources give zero results.
- Sign bits match the source sign.

Correct rounded values need the bench's sweep of every type, precision and mode over directed and pseudo-random sources, compared against an arithmetic reference. That sweep covers tie cases, all-ones carries into the exponent and the irrelevance of the upper source half. The assertions cannot show these.

// File: rtl/itof_pkg.sv
package itof_pkg;

  typedef enum logic [1:0] {
    KIND_S32 = 2'd0,
    KIND_U32 = 2'd1,
    KIND_S64 = 2'd2,
    KIND_U64 = 2'd3
  } int_kind_t;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rnd_mode_t;

  localparam logic [4:0] CLASS_NONE  = 5'b00000;
  localparam logic [4:0] CLASS_PZERO = 5'b00010;
  localparam logic [4:0] CLASS_PNORM = 5'b00100;
  localparam logic [4:0] CLASS_NNORM = 5'b01000;

  // Decide whether the kept significand is incremented.
  function automatic logic round_increment(input rnd_mode_t mode,
                                           input logic neg,
                                           input logic lsb,
                                           input logic guard,
                                           input logic sticky);
    logic lost;
    lost = guard | sticky;
    case (mode)
      RM_NEAR_EVEN: round_increment = guard & (sticky | lsb);
      RM_TO_ZERO:   round_increment = 1'b0;
      RM_TO_POS:    round_increment = lost & ~neg;
      default:      round_increment = lost & neg;
    endcase
  endfunction

  // Integer sources only ever yield zero or normal numbers.
  function automatic logic [4:0] class_code(input logic is_zero, input logic neg);
    if (is_zero)  class_code = CLASS_PZERO;
    else if (neg) class_code = CLASS_NNORM;
    else          class_code = CLASS_PNORM;
  endfunction

  // Biased exponent from the leading-zero count and the rounding carry.
  function automatic logic [10:0] biased_exp(input logic [6:0] lead_zeros,
                                             input logic carry);
    biased_exp = 11'(1023 + 63) - 11'(lead_zeros) + 11'(carry);
  endfunction

endpackage

// File: rtl/itof_operand.sv
module itof_operand
  import itof_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] src,
  input  logic [1:0]   kind,
  output logic [W-1:0] mag,
  output logic         neg,
  output logic         is_zero
);
  localparam int HALF = W / 2;

  logic [HALF-1:0] lo;
  logic [W-1:0]    lo_sext;
  logic [W-1:0]    lo_zext;

  assign lo      = src[HALF-1:0];
  assign lo_sext = {{(W-HALF){lo[HALF-1]}}, lo};
  assign lo_zext = {{(W-HALF){1'b0}}, lo};

  always_comb begin
    case (int_kind_t'(kind))
      KIND_S32: begin
        neg = lo[HALF-1];
        mag = neg ? (~lo_sext + 1'b1) : lo_sext;
      end
      KIND_U32: begin
        neg = 1'b0;
        mag = lo_zext;
      end
      KIND_S64: begin
        neg = src[W-1];
        mag = neg ? (~src + 1'b1) : src;
      end
      default: begin
        neg = 1'b0;
        mag = src;
      end
    endcase
  end

  assign is_zero = (mag == '0);
endmodule

// File: rtl/itof_lzc.sv
module itof_lzc #(
  parameter int W     = 64,
  parameter int CNT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     value,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (value[i]) count = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/itof_round.sv
module itof_round
  import itof_pkg::*;
#(
  parameter int W      = 64,
  parameter int MANT_W = 52
) (
  input  logic [W-1:0]      norm,
  input  logic              neg,
  input  logic [1:0]        mode,
  output logic [MANT_W-1:0] frac,
  output logic              carry,
  output logic              lost,
  output logic              incr
);
  localparam int P = MANT_W + 1;

  logic [P-1:0] keep;
  logic         guard;
  logic         sticky;

  assign keep   = norm[W-1 -: P];
  assign guard  = norm[W-1-P];
  assign sticky = |norm[W-2-P:0];

  assign lost  = guard | sticky;
  assign incr  = round_increment(rnd_mode_t'(mode), neg, keep[0], guard, sticky);
  assign carry = incr & (&keep);
  assign frac  = keep[MANT_W-1:0] + MANT_W'(incr);
endmodule

// File: rtl/itof_convert.sv
module itof_convert
  import itof_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int EXP_W    = 11,
  parameter int DBL_FRAC = 52,
  parameter int SGL_FRAC = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] int_src,
  input  logic [1:0]        int_kind,
  input  logic              single_sel,
  input  logic [1:0]        rnd_mode,
  output logic [DATA_W-1:0] fp_result,
  output logic [4:0]        fp_class,
  output logic              inexact,
  output logic              frac_rounded
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam int NPREC = 2;

  logic [DATA_W-1:0] mag;
  logic [DATA_W-1:0] norm;
  logic [CNT_W-1:0]  lead_zeros;
  logic              neg_val;
  logic              mag_zero;
  logic              bypass_path;

  logic [NPREC-1:0][DBL_FRAC-1:0] frac_al;
  logic [NPREC-1:0]               carry_v;
  logic [NPREC-1:0]               lost_v;
  logic [NPREC-1:0]               up_v;

  logic              round_up;
  logic              round_lost;
  logic [EXP_W-1:0]  exp_field;
  logic [DATA_W-1:0] result_d;

  itof_operand #(.W(DATA_W)) u_operand (
    .src     (int_src),
    .kind    (int_kind),
    .mag     (mag),
    .neg     (neg_val),
    .is_zero (mag_zero)
  );

  itof_lzc #(.W(DATA_W), .CNT_W(CNT_W)) u_lzc (
    .value (mag),
    .count (lead_zeros)
  );

  assign norm = mag << lead_zeros;

  // Index 0 rounds to double precision, index 1 to single precision.
  for (genvar g = 0; g < NPREC; g++) begin : g_prec
    localparam int F = (g == 0) ? DBL_FRAC : SGL_FRAC;
    logic [F-1:0] frac_g;

    itof_round #(.W(DATA_W), .MANT_W(F)) u_round (
      .norm  (norm),
      .neg   (neg_val),
      .mode  (rnd_mode),
      .frac  (frac_g),
      .carry (carry_v[g]),
      .lost  (lost_v[g]),
      .incr  (up_v[g])
    );

    assign frac_al[g] = DBL_FRAC'(frac_g) << (DBL_FRAC - F);
  end

  assign bypass_path = ~single_sel & ~int_kind[1];
  assign round_up    = up_v[single_sel];
  assign round_lost  = lost_v[single_sel];
  assign exp_field   = biased_exp(lead_zeros, carry_v[single_sel]);
  assign result_d    = mag_zero ? '0 : {neg_val, exp_field, frac_al[single_sel]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_result    <= '0;
      fp_class     <= CLASS_NONE;
      inexact      <= 1'b0;
      frac_rounded <= 1'b0;
    end else begin
      fp_result    <= result_d;
      fp_class     <= bypass_path ? CLASS_NONE : class_code(mag_zero, neg_val);
      inexact      <= ~bypass_path & round_lost;
      frac_rounded <= ~bypass_path & round_up;
    end
  end
endmodule

// File: rtl/itof_convert_chk.sv
module itof_convert_chk #(
  parameter int DATA_W = 64,
  parameter int PAD_W  = 29
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        int_kind,
  input logic              single_sel,
  input logic [1:0]        rnd_mode,
  input logic [DATA_W-1:0] fp_result,
  input logic [4:0]        fp_class,
  input logic              inexact,
  input logic              frac_rounded,
  input logic              bypass_path,
  input logic              mag_zero,
  input logic              round_up,
  input logic              neg_val
);

  assert_bypass_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_path |=> (!inexact && !frac_rounded && fp_class == 5'b00000));

  assert_single_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    single_sel |=> (fp_result[PAD_W-1:0] == '0));

  assert_up_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    round_up |=> frac_rounded);

  assert_up_implies_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frac_rounded |-> inexact);

  assert_truncate_no_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_mode == 2'b01) |=> !frac_rounded);

  assert_zero_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mag_zero |=> (fp_result == '0));

  assert_unsigned_positive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_kind[0] |=> !fp_result[DATA_W-1]);

  assert_negative_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    neg_val |=> fp_result[DATA_W-1]);

  assert_class_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_zero && !bypass_path) |=> (fp_class == 5'b00010));

  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fp_result == '0 && fp_class == '0 && !inexact && !frac_rounded));

endmodule

bind itof_convert itof_convert_chk #(
  .DATA_W (DATA_W),
  .PAD_W  (DBL_FRAC - SGL_FRAC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .int_kind     (int_kind),
  .single_sel   (single_sel),
  .rnd_mode     (rnd_mode),
  .fp_result    (fp_result),
  .fp_class     (fp_class),
  .inexact      (inexact),
  .frac_rounded (frac_rounded),
  .bypass_path  (bypass_path),
  .mag_zero     (mag_zero),
  .round_up     (round_up),
  .neg_val      (neg_val)
);

// File: tb/itof_convert_test.sv
module itof_convert_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] res;
    logic [4:0]  cls;
    logic        inx;
    logic        fr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] int_src = '0;
  logic [1:0]  int_kind = '0;
  logic        single_sel = 1'b0;
  logic [1:0]  rnd_mode = '0;
  logic [63:0] fp_result;
  logic [4:0]  fp_class;
  logic        inexact;
  logic        frac_rounded;

  int checks = 0;
  int failures = 0;

  itof_convert uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .int_src      (int_src),
    .int_kind     (int_kind),
    .single_sel   (single_sel),
    .rnd_mode     (rnd_mode),
    .fp_result    (fp_result),
    .fp_class     (fp_class),
    .inexact      (inexact),
    .frac_rounded (frac_rounded)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish (got=hung exp=done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h (src=%h kind=%0d sgl=%0b rm=%0d)",
               req, got, exp, int_src, int_kind, single_sel, rnd_mode);
    end
  endtask

  // Reference: locate the top bit, split quotient and remainder, compare to half.
  function automatic exp_t model(input logic [63:0] s, input logic [1:0] k,
                                 input logic sg, input logic [1:0] rm);
    exp_t e;
    logic [63:0] mag, q, r, half;
    logic neg, up, byp;
    logic [10:0] ex;
    int msb, p, sh;
    byp = !sg && !k[1];
    case (k)
      2'd0: begin neg = s[31]; mag = neg ? (64'd0 - {{32{1'b1}}, s[31:0]}) : {32'd0, s[31:0]}; end
      2'd1: begin neg = 1'b0; mag = {32'd0, s[31:0]}; end
      2'd2: begin neg = s[63]; mag = neg ? (64'd0 - s) : s; end
      default: begin neg = 1'b0; mag = s; end
    endcase
    e = '0;
    if (mag == 0) begin
      e.cls = byp ? 5'b00000 : 5'b00010;
      return e;
    end
    msb = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) msb = i;
    p = sg ? 24 : 53;
    up = 1'b0;
    if (msb < p) begin
      q = mag << (p - 1 - msb);
    end else begin
      sh = msb - (p - 1);
      q = mag >> sh;
      r = mag - (q << sh);
      half = 64'd1 << (sh - 1);
      e.inx = (r != 0);
      case (rm)
        2'd0: up = (r > half) || (r == half && q[0]);
        2'd1: up = 1'b0;
        2'd2: up = e.inx && !neg;
        default: up = e.inx && neg;
      endcase
    end
    e.fr = up;
    q = q + 64'(up);
    ex = 11'(msb + 1023);
    if (q == (64'd1 << p)) begin
      q = q >> 1;
      ex = ex + 11'd1;
    end
    e.res = {neg, ex, (sg ? {q[22:0], 29'd0} : q[51:0])};
    e.cls = byp ? 5'b00000 : (neg ? 5'b01000 : 5'b00100);
    if (byp) begin
      e.inx = 1'b0;
      e.fr = 1'b0;
    end
    return e;
  endfunction

  task automatic drive(input logic [63:0] s, input logic [1:0] k,
                       input logic sg, input logic [1:0] rm);
    int_src = s;
    int_kind = k;
    single_sel = sg;
    rnd_mode = rm;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweep_one(input logic [63:0] s);
    for (int k = 0; k < 4; k++)
      for (int sg = 0; sg < 2; sg++)
        for (int rm = 0; rm < 4; rm++) begin
          exp_t e;
          string rtag;
          drive(s, 2'(k), 1'(sg), 2'(rm));
          e = model(s, 2'(k), 1'(sg), 2'(rm));
          if (sg == 0 && k < 2) rtag = "R2 value";
          else if (sg == 1) rtag = "R4 value";
          else rtag = "R3 value";
          check(rtag, fp_result, e.res);
          check("R7 class", 64'(fp_class), 64'(e.cls));
          check("R5 inexact", 64'(inexact), 64'(e.inx));
          check("R6 frac_rounded", 64'(frac_rounded), 64'(e.fr));
        end
  endtask

  logic [63:0] directed [16] = '{
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_8000_0000, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h0020_0000_0000_0001, 64'h0020_0000_0000_0003, 64'h8000_0000_0000_0400,
    64'h0000_0000_0100_0001, 64'h0000_0000_0100_0003, 64'hDEAD_BEEF_0000_0005,
    64'h0000_0000_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_0000_0000,
    64'h0000_00FF_FFFF_FF80
  };

  initial begin
    logic [63:0] lf;
    logic [63:0] a, b;

    repeat (3) @(negedge clk);
    // R11: outputs held at zero during reset
    check("R11 reset result", fp_result, 64'd0);
    check("R11 reset class", 64'(fp_class), 64'd0);
    check("R11 reset flags", 64'({inexact, frac_rounded}), 64'd0);
    rst_n = 1'b1;

    // R8: zero gives +0.0
    drive(64'd0, 2'd2, 1'b0, 2'd3);
    check("R8 zero value", fp_result, 64'd0);
    check("R7 zero class", 64'(fp_class), 64'h02);
    // R9: -1 as signed 32-bit
    drive(64'h0000_0000_FFFF_FFFF, 2'd0, 1'b0, 2'd0);
    check("R9 minus one", fp_result, 64'hBFF0_0000_0000_0000);
    check("R2 bypass class", 64'(fp_class), 64'd0);
    // R9: most negative values
    drive(64'h0000_0000_8000_0000, 2'd0, 1'b0, 2'd0);
    check("R9 min s32", fp_result, 64'hC1E0_0000_0000_0000);
    drive(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd0);
    check("R9 min s64", fp_result, 64'hC3E0_0000_0000_0000);
    check("R7 negative class", 64'(fp_class), 64'h08);
    check("R5 exact min s64", 64'(inexact), 64'd0);
    // R10: ties
    drive(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd0);
    check("R10 tie stays even", fp_result, 64'h4340_0000_0000_0000);
    check("R5 tie inexact", 64'(inexact), 64'd1);
    drive(64'h0020_0000_0000_0003, 2'd3, 1'b0, 2'd0);
    check("R10 tie goes even", fp_result, 64'h4340_0000_0000_0002);
    check("R6 tie up", 64'(frac_rounded), 64'd1);
    drive(64'h0000_0000_0100_0001, 2'd1, 1'b1, 2'd0);
    check("R10 single tie", fp_result, 64'h4170_0000_0000_0000);
    // R3: all-ones unsigned, carry into exponent vs truncation
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd0);
    check("R3 all ones nearest", fp_result, 64'h43F0_0000_0000_0000);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd1);
    check("R3 all ones truncate", fp_result, 64'h43EF_FFFF_FFFF_FFFF);
    check("R6 truncate no up", 64'(frac_rounded), 64'd0);
    // R1: upper half ignored for 32-bit types
    drive(64'hDEAD_BEEF_0000_0005, 2'd0, 1'b0, 2'd0);
    check("R1 upper ignored", fp_result, 64'h4014_0000_0000_0000);
    for (int k = 0; k < 2; k++) begin
      drive(64'h0000_0000_8765_4321, 2'(k), 1'b1, 2'd2);
      a = fp_result;
      drive(64'h5A5A_A5A5_8765_4321, 2'(k), 1'b1, 2'd2);
      b = fp_result;
      check("R1 upper half no effect", b, a);
    end

    // R11: asynchronous reset mid-run
    drive(64'h0000_0000_0000_0007, 2'd3, 1'b0, 2'd0);
    rst_n = 1'b0;
    #1;
    check("R11 async clear", fp_result, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: one-cycle latency
    int_src = 64'd3; int_kind = 2'd3; single_sel = 1'b0; rnd_mode = 2'd0;
    #1;
    check("R11 not yet updated", fp_result, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R11 one cycle latency", fp_result, 64'h4008_0000_0000_0000);

    // Sweeps over every type, precision and mode
    for (int i = 0; i < 16; i++) sweep_one(directed[i]);
    lf = 64'h1234_5678_9ABC_DEF1;
    for (int i = 0; i < 200; i++) begin
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 7);
      lf = lf ^ (lf << 17);
      sweep_one((i % 3 == 0) ? ~(lf >> (i % 64)) : (lf >> (i % 64)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule